// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device has left stuck, typically because the target kept its supply through a system reset and is still partway through a transfer. When started, it takes direct control of the clock and data lines through open-drain pull-low enables and samples both lines. It then works through a fixed recovery procedure and reports the outcome as a two-bit status code.

The procedure has three parts. First, it waits a bounded number of bit delays for a target that is stretching the clock. Next, if data is low, it clocks the bus until the target lets go of data. Last, it generates a STOP condition. The number of rounds is bounded. A tick input marks each bit delay, which is about 5 µs for a standard-speed bus. The block performs no normal transfers. It is meant to run only while the regular controller has given up the pins.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, both pull-low enables are off, busy and done are low, and the status code is 00.
- R2: A start pulse while idle raises busy on the next clock. A start pulse while busy is ignored and does not begin a second run.
- R3: If SCL reads low at entry, the block re-checks SCL once per tick. If SCL is still low at the 10th tick, the block finishes with status 01, whatever the level of SDA, and pulls neither line at any point.
- R4: If SCL rises while the block is waiting for it, the block goes on to check SDA and does not report a clock failure.
- R5: If SDA reads high once SCL is high, the block finishes with status 00 without pulling either line.
- R6: A recovery round starts with SCL released for one tick. SCL is then pulled low for one tick and released for one tick, up to 9 times. SDA is checked before each pull, and the pulls stop as soon as SDA reads high. SCL is only pulled low on a cycle right after a tick.
- R7: After the clock pulses of a round, SDA is pulled low for one tick while SCL is released, then SDA is released for one tick. This forms a STOP. SDA is never pulled while SCL is pulled.
- R8: A round that ends with SDA and SCL both high ends the procedure. At most 3 rounds are run.
- R9: At the end of the rounds, status bit 0 is set when SCL reads low and status bit 1 is set when SDA reads low. So the codes are 00 ok, 01 clock stuck, 10 data stuck and 11 both stuck.
- R10: On completion, done is high for exactly one clock while busy is low. Both lines are released whenever busy is low, and the status code is held until the next run finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a recovery run |
| tick_i | input | 1 | One-clock pulse marking the end of each bit delay |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull_o | output | 1 | Pull SCL low when high (open-drain enable) |
| sda_pull_o | output | 1 | Pull SDA low when high (open-drain enable) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-clock pulse at the end of a run |
| status_o | output | 2 | Outcome: bit 0 SCL stuck low, bit 1 SDA stuck low |

## Verification
The assertions assume that tick_i is a single-clock pulse and that the line inputs are already synchronized to clk. They also assume that the bus levels are the wired-AND of the block's own pull enables and the target's holds, so that a released line reads high unless a target holds it. The bench builds both lines as exactly that wired-AND and produces tick_i from a free-running divider every fourth clock. The target behaviour (holding the clock for a while or forever, holding data until a given number of clock falls, or holding the clock from the first STOP onward) is driven on falling clock edges. This keeps every input stable around the sampling edge.

// File: rtl/i2c_bus_unstick_pkg.sv
// Package: shared state encoding and status codes for the bus recovery sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package i2c_bus_unstick_pkg;

    typedef enum logic [2:0] {
        UN_IDLE   = 3'd0,
        UN_CHECK  = 3'd1,
        UN_STRETCH= 3'd2,
        UN_CLK_HI = 3'd3,
        UN_CLK_LO = 3'd4,
        UN_STOP_LO= 3'd5,
        UN_STOP_HI= 3'd6
    } unstick_state_t;

    localparam logic [1:0] CODE_OK      = 2'b00;
    localparam logic [1:0] CODE_SCL_BAD = 2'b01;

endpackage

// File: rtl/unstick_counter.sv
// Module: bounded up-counter used for stretch waits, clock pulses and rounds.
// Assumes: clr has priority over inc; the caller never increments past LIMIT.
module unstick_counter #(
    parameter int LIMIT = 9,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o,
    output logic         last_o,
    output logic         full_o
);

    logic [W-1:0] cnt_q;

    // Count register: cleared on request, advanced by one on inc.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (inc)  cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == W'(LIMIT - 1));
    assign full_o = (cnt_q == W'(LIMIT));

endmodule

// File: rtl/unstick_status_enc.sv
// Module: maps sampled line levels to the two-bit outcome code.
// Assumes: line inputs are synchronous samples; a low line means stuck.
module unstick_status_enc (
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    output logic [1:0] code_o
);

    // Bit 1 flags data stuck low, bit 0 flags clock stuck low.
    always_comb begin
        code_o = {~sda_lvl, ~scl_lvl};
    end

endmodule

// File: rtl/i2c_bus_unstick.sv
// Module: I2C bus recovery sequencer top. On start it samples both lines,
// waits a bounded time for clock stretching, then runs up to ROUNDS rounds
// of at most PULSES clock pulses each followed by a forced STOP, and reports
// the outcome.
// Assumes: tick_i is a one-clock pulse per bit delay; scl_in/sda_in are
// synchronized to clk; the lines are open-drain (released reads high unless held).
module i2c_bus_unstick
    import i2c_bus_unstick_pkg::*;
#(
    parameter int STRETCH_CHECKS = 10,
    parameter int PULSES         = 9,
    parameter int ROUNDS         = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       tick_i,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull_o,
    output logic       sda_pull_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] status_o
);

    localparam int WW = $clog2(STRETCH_CHECKS + 1);
    localparam int PW = $clog2(PULSES + 1);
    localparam int RW = $clog2(ROUNDS + 1);

    unstick_state_t st_q, st_d;
    logic           done_q;
    logic [1:0]     status_q;
    logic [1:0]     fin_code, enc_code;
    logic           fin;
    logic           wait_clr, wait_inc, wait_last;
    logic           pls_clr, pls_inc, pls_full;
    logic           rnd_clr, rnd_inc, rnd_last;
    logic [WW-1:0]  wait_cnt;
    logic [PW-1:0]  pls_cnt;
    logic [RW-1:0]  rnd_cnt;
    logic           wait_unused_l, wait_unused_f;
    logic           pls_unused_l;
    logic           rnd_unused_f;

    unstick_counter #(.LIMIT(STRETCH_CHECKS)) u_wait_cnt (
        .clk(clk), .rst_n(rst_n), .clr(wait_clr), .inc(wait_inc),
        .cnt_o(wait_cnt), .last_o(wait_last), .full_o(wait_unused_f)
    );

    unstick_counter #(.LIMIT(PULSES)) u_pulse_cnt (
        .clk(clk), .rst_n(rst_n), .clr(pls_clr), .inc(pls_inc),
        .cnt_o(pls_cnt), .last_o(pls_unused_l), .full_o(pls_full)
    );

    unstick_counter #(.LIMIT(ROUNDS)) u_round_cnt (
        .clk(clk), .rst_n(rst_n), .clr(rnd_clr), .inc(rnd_inc),
        .cnt_o(rnd_cnt), .last_o(rnd_last), .full_o(rnd_unused_f)
    );

    unstick_status_enc u_enc (
        .scl_lvl(scl_in), .sda_lvl(sda_in), .code_o(enc_code)
    );

    assign wait_unused_l = 1'b0;

    // Next-state and counter control for the recovery procedure.
    always_comb begin
        st_d     = st_q;
        fin      = 1'b0;
        fin_code = enc_code;
        wait_clr = 1'b0;
        wait_inc = 1'b0;
        pls_clr  = 1'b0;
        pls_inc  = 1'b0;
        rnd_clr  = 1'b0;
        rnd_inc  = 1'b0;
        unique case (st_q)
            UN_IDLE: begin
                if (start_i) begin
                    st_d     = UN_CHECK;
                    wait_clr = 1'b1;
                    rnd_clr  = 1'b1;
                end
            end
            UN_CHECK: begin
                if (!scl_in) begin
                    st_d = UN_STRETCH;
                end else if (sda_in) begin
                    fin = 1'b1;
                end else begin
                    st_d    = UN_CLK_HI;
                    pls_clr = 1'b1;
                end
            end
            UN_STRETCH: begin
                if (tick_i) begin
                    if (scl_in && sda_in) begin
                        fin = 1'b1;
                    end else if (scl_in) begin
                        st_d    = UN_CLK_HI;
                        pls_clr = 1'b1;
                    end else if (wait_last) begin
                        fin      = 1'b1;
                        fin_code = CODE_SCL_BAD;
                    end else begin
                        wait_inc = 1'b1;
                    end
                end
            end
            UN_CLK_HI: begin
                if (tick_i) begin
                    if (sda_in || pls_full) begin
                        st_d = UN_STOP_LO;
                    end else begin
                        st_d    = UN_CLK_LO;
                        pls_inc = 1'b1;
                    end
                end
            end
            UN_CLK_LO: begin
                if (tick_i) st_d = UN_CLK_HI;
            end
            UN_STOP_LO: begin
                if (tick_i) st_d = UN_STOP_HI;
            end
            UN_STOP_HI: begin
                if (tick_i) begin
                    if ((scl_in && sda_in) || rnd_last) begin
                        fin = 1'b1;
                    end else begin
                        st_d    = UN_CLK_HI;
                        rnd_inc = 1'b1;
                        pls_clr = 1'b1;
                    end
                end
            end
            default: st_d = UN_IDLE;
        endcase
        if (fin) st_d = UN_IDLE;
    end

    // State, completion pulse and held status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= UN_IDLE;
            done_q   <= 1'b0;
            status_q <= CODE_OK;
        end else begin
            st_q   <= st_d;
            done_q <= fin;
            if (fin) status_q <= fin_code;
        end
    end

    assign scl_pull_o = (st_q == UN_CLK_LO);
    assign sda_pull_o = (st_q == UN_STOP_LO);
    assign busy_o     = (st_q != UN_IDLE);
    assign done_o     = done_q;
    assign status_o   = status_q;

    // R2: a run begins only in response to a start request.
    p_start_begins_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R6: SCL is pulled low only at a bit-delay boundary.
    p_pull_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_o) |-> $past(tick_i));

    // R7: SDA is only pulled while SCL is released.
    p_stop_scl_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_o |-> !scl_pull_o);

    // R9: status bit 0 reflects SCL at the finishing sample.
    p_status_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o[0] == !$past(scl_in)));

    // R10: done is a single-cycle pulse issued with busy low.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R10: lines are released while idle.
    p_idle_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_pull_o && !sda_pull_o));

    // R6: pulse count never exceeds its bound.
    p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pls_cnt <= PW'(PULSES));

    // R8: round index stays below the round bound.
    p_round_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_cnt < RW'(ROUNDS));

    // R3: stretch wait index stays below the check bound.
    p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < WW'(STRETCH_CHECKS));

endmodule

// File: tb/i2c_bus_unstick_bench.sv
module i2c_bus_unstick_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       tick_i = 1'b0;
    logic       scl_in, sda_in;
    logic       scl_pull_o, sda_pull_o, busy_o, done_o;
    logic [1:0] status_o;

    int checks = 0;
    int fails  = 0;

    // Target model controls, written only by the stimulus process.
    logic scl_hold = 1'b0;
    logic sda_hold = 1'b0;
    logic scl_hold_after_stop = 1'b0;
    int   sda_rel_at = 0;
    int   base_falls = 0;
    int   base_stops = 0;
    int   base_dones = 0;

    // Monitor counters, written only by the monitor process.
    int   falls = 0;
    int   stops = 0;
    int   dones = 0;
    int   overlap = 0;
    int   tdiv = 0;
    int   cycles = 0;
    logic scl_pull_prev = 1'b0;
    logic sda_pull_prev = 1'b0;

    always #4 clk = ~clk;

    assign scl_in = ~(scl_pull_o | scl_hold |
                      (scl_hold_after_stop && (stops - base_stops) >= 1));
    assign sda_in = ~(sda_pull_o |
                      (sda_hold && !(sda_rel_at != 0 && (falls - base_falls) >= sda_rel_at)));

    i2c_bus_unstick u_i2c_bus_unstick (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
        .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
    );

    // Tick divider and bus event monitor, all on the falling edge.
    always @(negedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick_i <= (tdiv == 3);
        if (scl_pull_o && !scl_pull_prev) falls <= falls + 1;
        if (sda_pull_o && !sda_pull_prev) stops <= stops + 1;
        if (done_o) dones <= dones + 1;
        if (scl_pull_o && sda_pull_o) overlap <= overlap + 1;
        scl_pull_prev <= scl_pull_o;
        sda_pull_prev <= sda_pull_o;
        cycles <= cycles + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic prep();
        @(negedge clk);
        base_falls = falls;
        base_stops = stops;
        base_dones = dones;
    endtask

    task automatic kick();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    endtask

    // Wait for done; checks its one-cycle width and released lines (R10).
    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done_o == 1'b1, "R10 done seen (watchdog)", done_o, 1);
        check(busy_o == 1'b0, "R10 busy low at done", busy_o, 0);
        check(!scl_pull_o && !sda_pull_o, "R10 lines released", {scl_pull_o, sda_pull_o}, 0);
        @(negedge clk);
        check(done_o == 1'b0, "R10 done one cycle", done_o, 0);
    endtask

    task automatic settle();
        scl_hold = 1'b0; sda_hold = 1'b0; scl_hold_after_stop = 1'b0; sda_rel_at = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        check(!scl_pull_o && !sda_pull_o, "R1 lines released", {scl_pull_o, sda_pull_o}, 0);
        check(!busy_o && !done_o, "R1 busy/done low", {busy_o, done_o}, 0);
        check(status_o == 2'b00, "R1 status", status_o, 0);
    endtask

    task automatic t_idle_bus();
        prep();
        kick();
        wait_done();
        check(status_o == 2'b00, "R5 status ok", status_o, 0);
        check(falls - base_falls == 0, "R5 no clocks", falls - base_falls, 0);
        check(stops - base_stops == 0, "R5 no stop", stops - base_stops, 0);
        settle();
    endtask

    task automatic t_scl_stuck();
        int ticks = 0;
        scl_hold = 1'b1; sda_hold = 1'b1;
        prep();
        kick();
        while (!done_o && ticks < 100) begin
            @(negedge clk);
            if (tick_i) ticks++;
        end
        check(ticks >= 9 && ticks <= 11, "R3 ten checks", ticks, 10);
        wait_done();
        check(status_o == 2'b01, "R3 status clock stuck", status_o, 1);
        check(falls - base_falls == 0, "R3 no clocks", falls - base_falls, 0);
        check(stops - base_stops == 0, "R3 no stop", stops - base_stops, 0);
        settle();
    endtask

    task automatic t_stretch_ends();
        int ticks = 0;
        scl_hold = 1'b1;
        prep();
        kick();
        while (ticks < 3) begin
            @(negedge clk);
            if (tick_i) ticks++;
        end
        scl_hold = 1'b0;
        wait_done();
        check(status_o == 2'b00, "R4 stretch released ok", status_o, 0);
        check(falls - base_falls == 0, "R4 no clocks", falls - base_falls, 0);
        settle();
    endtask

    task automatic t_release_after(input int n, input int exp_stops, input string req);
        sda_hold = 1'b1; sda_rel_at = n;
        prep();
        kick();
        wait_done();
        check(status_o == 2'b00, {req, " status ok"}, status_o, 0);
        check(falls - base_falls == n, {req, " clock count"}, falls - base_falls, n);
        check(stops - base_stops == exp_stops, {req, " stop count"}, stops - base_stops, exp_stops);
        settle();
    endtask

    task automatic t_sda_stuck();
        sda_hold = 1'b1;
        prep();
        kick();
        repeat (40) @(negedge clk);
        start_i = 1'b1;                 // R2: start while busy must be ignored
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        check(status_o == 2'b10, "R9 status data stuck", status_o, 2);
        check(falls - base_falls == 27, "R8 three full rounds", falls - base_falls, 27);
        check(stops - base_stops == 3, "R7 stop per round", stops - base_stops, 3);
        check(overlap == 0, "R7 no pull overlap", overlap, 0);
        repeat (4) @(negedge clk);
        check(dones - base_dones == 1, "R2 single run", dones - base_dones, 1);
        check(!busy_o, "R2 no second run", busy_o, 0);
        settle();
    endtask

    task automatic t_both_stuck();
        sda_hold = 1'b1; scl_hold_after_stop = 1'b1;
        prep();
        kick();
        wait_done();
        check(status_o == 2'b11, "R9 status both stuck", status_o, 3);
        check(stops - base_stops == 3, "R8 three rounds", stops - base_stops, 3);
        settle();
        check(status_o == 2'b11, "R10 status held", status_o, 3);
    endtask

    task automatic t_pulse_spacing();
        int gap = 0;
        int seen = 0;
        sda_hold = 1'b1; sda_rel_at = 3;
        prep();
        kick();
        while (!scl_pull_o) @(negedge clk);
        while (scl_pull_o) begin @(negedge clk); gap++; end
        check(gap == 4, "R6 low phase one delay", gap, 4);
        gap = 0;
        while (!scl_pull_o && !sda_pull_o) begin @(negedge clk); gap++; end
        seen = scl_pull_o;
        check(gap == 4, "R6 high phase one delay", gap, 4);
        check(seen == 1, "R6 second pulse follows", seen, 1);
        wait_done();
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_idle_bus();
        t_scl_stuck();
        t_stretch_ends();
        t_release_after(4, 1, "R6");
        t_release_after(10, 2, "R8");
        t_pulse_spacing();
        t_sda_stuck();
        t_both_stuck();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Global watchdog: a hung run counts as a failure and still reports.
    initial begin
        #1200000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule